// File: doc/BRIEF.md
# Dataflow Thread Synchronization Unit

This unit keeps the activation frames of non-blocking dataflow threads. A producer asks for a frame by presenting a thread entry address and the number of inputs that thread still waits for. The unit answers with a frame identifier. Every argument that later lands in a frame is reported as an argument event, and each event lowers that frame's remaining-input count by one. When the count reaches zero, all inputs have arrived. The frame identifier and its entry address then go into a first-in, first-out ready queue, which the pre-load stage drains.

A dispatched thread always runs to completion. The unit never takes a queued thread back and never preempts it. A release request returns a frame to the free pool. This lets the unused half of a conditional pair of threads be thrown away, even before it becomes ready.

The unit holds sixteen frames. When several are free, it always grants the lowest-numbered one. An allocation that finds no free frame waits on its handshake and is never lost. An argument event that names an unallocated frame, or a frame whose count is already zero, sets a sticky error flag and changes nothing else.

Top module: `tsync_unit`

## Requirements
- R1: After reset no frame is held, `alloc_ready` is 1 with `alloc_fid` equal to 0, `rdy_valid` is 0 and `err_sticky` is 0.
- R2: While `alloc_ready` is 1, `alloc_fid` names the lowest-numbered free frame. An allocation accepted on a clock edge marks that frame as held from the next cycle.
- R3: With all 16 frames held, `alloc_ready` stays 0 and a pending request waits. After a frame is released, the waiting request is granted that frame's identifier.
- R4: An accepted argument event lowers the named frame's count by one. The event that brings the count from 1 to 0 makes the frame identifier and entry address visible at the ready-queue head on the next cycle. Earlier events add nothing to the queue.
- R5: The ready queue hands out frames in the order their counts reached zero. While `rdy_valid` is 1 and `rdy_ready` is 0, the head is held.
- R6: An accepted argument event aimed at an unallocated frame, or at a frame whose count is 0, sets `err_sticky`. It leaves every frame count and the ready queue unchanged.
- R7: While the ready queue holds 8 entries, `arg_ready` is 0 and argument events wait. One pop makes `arg_ready` 1 again.
- R8: When a release and an accepted argument event name the same frame in the same cycle, the release wins. The frame is freed, no queue entry is made and `err_sticky` does not change.
- R9: `err_sticky` stays 1 until reset, whatever the later traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_entry | input | 16 | Thread entry address for the new frame |
| alloc_count | input | 4 | Number of inputs the thread waits for (nonzero) |
| alloc_ready | output | 1 | A free frame exists; the request is taken on this edge |
| alloc_fid | output | 4 | Identifier of the frame being granted |
| arg_valid | input | 1 | Argument event present |
| arg_fid | input | 4 | Frame the argument lands in |
| arg_ready | output | 1 | Argument event accepted on this edge |
| free_valid | input | 1 | Release request |
| free_fid | input | 4 | Frame to release |
| rdy_valid | output | 1 | Ready queue is not empty |
| rdy_ready | input | 1 | Pre-load stage takes the head entry |
| rdy_fid | output | 4 | Frame identifier at the queue head |
| rdy_entry | output | 16 | Entry address at the queue head |
| err_sticky | output | 1 | An invalid argument event has been seen since reset |

## Verification
The checker assumes that every allocation request carries a nonzero input count. A thread with no inputs would otherwise be held forever without ever being queued. The checker also assumes that the pre-load stage raises `rdy_ready` only while it is willing to take the head. The bench always allocates with counts of one or more. It releases only frames it allocated itself, or frames it is deliberately racing against an argument event. It pops only when `rdy_valid` is set, so the stimulus stays inside these assumptions.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
    localparam int NUM_FRAMES = 16;
    localparam int FID_W      = $clog2(NUM_FRAMES);
    localparam int CNT_W      = 4;
    localparam int ADDR_W     = 16;
    localparam int QDEPTH     = 8;
    localparam int QCNT_W     = $clog2(QDEPTH + 1);

    typedef logic [FID_W-1:0]  fid_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        fid_t  fid;
        addr_t entry;
    } rdy_t;

    function automatic logic is_last_input(input cnt_t c);
        return c == cnt_t'(1);
    endfunction
endpackage

// File: rtl/tsync_lowfree.sv
module tsync_lowfree #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     held_map,
    output logic             any_free,
    output logic [IDX_W-1:0] low_idx
);
    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!held_map[i]) low_idx = IDX_W'(i);
        end
        any_free = ~&held_map;
    end
endmodule

// File: rtl/tsync_frame_table.sv
module tsync_frame_table #(
    parameter int N      = 16,
    parameter int FID_W  = $clog2(N),
    parameter int CNT_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_we,
    input  logic [FID_W-1:0]  alloc_fid,
    input  logic [CNT_W-1:0]  alloc_cnt,
    input  logic [ADDR_W-1:0] alloc_entry,
    input  logic              dec_we,
    input  logic [FID_W-1:0]  dec_fid,
    input  logic              free_we,
    input  logic [FID_W-1:0]  free_fid,
    input  logic [FID_W-1:0]  rd_fid,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [ADDR_W-1:0] rd_entry,
    output logic [N-1:0]      held_map
);
    logic [CNT_W-1:0]  cnt_q   [N];
    logic [ADDR_W-1:0] entry_q [N];

    for (genvar g = 0; g < N; g++) begin : g_frame
        localparam logic [FID_W-1:0] ID = FID_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                held_map[g] <= 1'b0;
                cnt_q[g]    <= '0;
                entry_q[g]  <= '0;
            end else begin
                if (free_we && free_fid == ID) held_map[g] <= 1'b0;
                if (dec_we && dec_fid == ID)   cnt_q[g] <= cnt_q[g] - 1'b1;
                if (alloc_we && alloc_fid == ID) begin
                    held_map[g] <= 1'b1;
                    cnt_q[g]    <= alloc_cnt;
                    entry_q[g]  <= alloc_entry;
                end
            end
        end
    end

    assign rd_cnt   = cnt_q[rd_fid];
    assign rd_entry = entry_q[rd_fid];
endmodule

// File: rtl/tsync_fifo.sv
module tsync_fifo #(
    parameter int W      = 20,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            level <= level + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_data = mem[rd_ptr];
endmodule

// File: rtl/tsync_unit.sv
module tsync_unit
    import tsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_entry,
    input  logic [CNT_W-1:0]  alloc_count,
    output logic              alloc_ready,
    output logic [FID_W-1:0]  alloc_fid,
    input  logic              arg_valid,
    input  logic [FID_W-1:0]  arg_fid,
    output logic              arg_ready,
    input  logic              free_valid,
    input  logic [FID_W-1:0]  free_fid,
    output logic              rdy_valid,
    input  logic              rdy_ready,
    output logic [FID_W-1:0]  rdy_fid,
    output logic [ADDR_W-1:0] rdy_entry,
    output logic              err_sticky
);
    logic [NUM_FRAMES-1:0] live_map;
    logic [QCNT_W-1:0]     q_count;
    cnt_t                  arg_cnt;
    addr_t                 arg_entry;
    rdy_t                  push_item, head_item;
    logic alloc_fire, arg_fire, free_hit, arg_bad, dec_we, err_set, q_push, q_pop;

    tsync_lowfree #(.N(NUM_FRAMES), .IDX_W(FID_W)) picker_i (
        .held_map (live_map),
        .any_free (alloc_ready),
        .low_idx  (alloc_fid)
    );

    assign alloc_fire = alloc_valid && alloc_ready;
    assign arg_ready  = (q_count != QCNT_W'(QDEPTH));
    assign arg_fire   = arg_valid && arg_ready;
    assign free_hit   = free_valid && (free_fid == arg_fid);
    assign arg_bad    = !live_map[arg_fid] || (arg_cnt == '0);
    assign dec_we     = arg_fire && !free_hit && !arg_bad;
    assign err_set    = arg_fire && !free_hit && arg_bad;
    assign q_push     = dec_we && is_last_input(arg_cnt);
    assign q_pop      = rdy_valid && rdy_ready;

    tsync_frame_table #(
        .N(NUM_FRAMES), .FID_W(FID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) table_i (
        .clk         (clk),
        .rst         (rst),
        .alloc_we    (alloc_fire),
        .alloc_fid   (alloc_fid),
        .alloc_cnt   (alloc_count),
        .alloc_entry (alloc_entry),
        .dec_we      (dec_we),
        .dec_fid     (arg_fid),
        .free_we     (free_valid),
        .free_fid    (free_fid),
        .rd_fid      (arg_fid),
        .rd_cnt      (arg_cnt),
        .rd_entry    (arg_entry),
        .held_map    (live_map)
    );

    assign push_item = '{fid: arg_fid, entry: arg_entry};

    tsync_fifo #(.W($bits(rdy_t)), .DEPTH(QDEPTH)) queue_i (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (push_item),
        .pop       (q_pop),
        .head_data (head_item),
        .level     (q_count)
    );

    assign rdy_valid = (q_count != '0);
    assign rdy_fid   = head_item.fid;
    assign rdy_entry = head_item.entry;

    always_ff @(posedge clk) begin
        if (rst)          err_sticky <= 1'b0;
        else if (err_set) err_sticky <= 1'b1;
    end
endmodule

// File: rtl/tsync_unit_chk.sv
module tsync_unit_chk
    import tsync_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  alloc_valid,
    input logic [CNT_W-1:0]      alloc_count,
    input logic                  alloc_ready,
    input logic [FID_W-1:0]      alloc_fid,
    input logic                  arg_valid,
    input logic                  arg_ready,
    input logic [FID_W-1:0]      arg_fid,
    input logic                  free_valid,
    input logic [FID_W-1:0]      free_fid,
    input logic                  rdy_valid,
    input logic                  rdy_ready,
    input logic [FID_W-1:0]      rdy_fid,
    input logic                  err_sticky,
    input logic [NUM_FRAMES-1:0] live_map,
    input logic [QCNT_W-1:0]     q_count
);
    AST_ALLOC_NONZERO: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> alloc_count != '0); // R4
    AST_GRANT_IS_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && alloc_ready |-> !live_map[alloc_fid]); // R2
    AST_GRANT_MARKS_HELD: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && alloc_ready |=> live_map[$past(alloc_fid)]); // R2
    AST_STALL_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && !alloc_ready && !free_valid |=> !alloc_ready); // R3
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        rdy_valid && !rdy_ready |=> rdy_valid && $stable(rdy_fid)); // R5
    AST_FULL_UNTIL_POP: assert property (@(posedge clk) disable iff (rst)
        q_count == QCNT_W'(QDEPTH) && !rdy_ready |=> q_count == QCNT_W'(QDEPTH)); // R7
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
        q_count <= QCNT_W'(QDEPTH)); // R7
    AST_RACE_FREE_WINS: assert property (@(posedge clk) disable iff (rst)
        free_valid && arg_valid && arg_ready && free_fid == arg_fid && !rdy_ready
        |=> $stable(err_sticky) && q_count == $past(q_count) && !live_map[$past(free_fid)]); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky); // R9
endmodule

bind tsync_unit tsync_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .alloc_count (alloc_count),
    .alloc_ready (alloc_ready),
    .alloc_fid   (alloc_fid),
    .arg_valid   (arg_valid),
    .arg_ready   (arg_ready),
    .arg_fid     (arg_fid),
    .free_valid  (free_valid),
    .free_fid    (free_fid),
    .rdy_valid   (rdy_valid),
    .rdy_ready   (rdy_ready),
    .rdy_fid     (rdy_fid),
    .err_sticky  (err_sticky),
    .live_map    (live_map),
    .q_count     (q_count)
);

// File: tb/tsync_unit_tb_top.sv
module tsync_unit_tb_top;
    import tsync_pkg::*;

    localparam real HALF = 2.5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 1'b0;
    logic [ADDR_W-1:0] alloc_entry = '0;
    logic [CNT_W-1:0]  alloc_count = 4'd1;
    logic alloc_ready;
    logic [FID_W-1:0] alloc_fid;
    logic arg_valid = 1'b0;
    logic [FID_W-1:0] arg_fid = '0;
    logic arg_ready;
    logic free_valid = 1'b0;
    logic [FID_W-1:0] free_fid = '0;
    logic rdy_valid;
    logic rdy_ready = 1'b0;
    logic [FID_W-1:0] rdy_fid;
    logic [ADDR_W-1:0] rdy_entry;
    logic err_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(HALF) clk = ~clk;

    tsync_unit dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk); #1 rst = 1'b0;
    endtask

    task automatic do_alloc(input int entry, input int cnt, output int fid);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_entry = ADDR_W'(entry); alloc_count = CNT_W'(cnt);
        #1 fid = alloc_fid;
        @(posedge clk); #1 alloc_valid = 1'b0;
    endtask

    task automatic do_arg(input int fid);
        @(negedge clk); arg_valid = 1'b1; arg_fid = FID_W'(fid);
        @(posedge clk); #1 arg_valid = 1'b0;
    endtask

    task automatic do_free(input int fid);
        @(negedge clk); free_valid = 1'b1; free_fid = FID_W'(fid);
        @(posedge clk); #1 free_valid = 1'b0;
    endtask

    task automatic do_pop(input string req, input int exp_fid, input int exp_entry);
        @(negedge clk);
        check(rdy_valid == 1'b1, req, "rdy_valid before pop", rdy_valid, 1);
        check(rdy_fid == FID_W'(exp_fid), req, "rdy_fid", rdy_fid, exp_fid);
        if (exp_entry >= 0)
            check(rdy_entry == ADDR_W'(exp_entry), req, "rdy_entry", rdy_entry, exp_entry);
        rdy_ready = 1'b1;
        @(posedge clk); #1 rdy_ready = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check(alloc_ready == 1'b1, "R1", "alloc_ready", alloc_ready, 1);
        check(alloc_fid == '0, "R1", "alloc_fid", alloc_fid, 0);
        check(rdy_valid == 1'b0, "R1", "rdy_valid", rdy_valid, 0);
        check(err_sticky == 1'b0, "R1", "err_sticky", err_sticky, 0);
    endtask

    task automatic t_lowest_first();
        int id;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            do_alloc(16'h40 + i, 2, id);
            check(id == i, "R2", "grant order", id, i);
        end
        do_free(1);
        do_alloc(16'h50, 2, id);
        check(id == 1, "R2", "reuse lowest freed", id, 1);
        do_alloc(16'h51, 2, id);
        check(id == 3, "R2", "next after holes", id, 3);
    endtask

    task automatic t_all_held();
        int id;
        do_reset();
        for (int i = 0; i < NUM_FRAMES; i++) do_alloc(i, 1, id);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_entry = 16'hBEEF; alloc_count = 4'd2;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(alloc_ready == 1'b0, "R3", "stall when full", alloc_ready, 0);
        free_valid = 1'b1; free_fid = 4'd9;
        @(posedge clk); #1 free_valid = 1'b0;
        @(negedge clk);
        check(alloc_ready == 1'b1, "R3", "ready after release", alloc_ready, 1);
        check(alloc_fid == 4'd9, "R3", "waiting request gets freed id", alloc_fid, 9);
        @(posedge clk); #1 alloc_valid = 1'b0;
        @(negedge clk);
        check(alloc_ready == 1'b0, "R3", "full again after grant", alloc_ready, 0);
        do_arg(9); do_arg(9);
        do_pop("R3", 9, 16'hBEEF);
    endtask

    task automatic t_countdown();
        int id;
        do_reset();
        do_alloc(16'hA0, 3, id);
        do_arg(id); do_arg(id);
        @(negedge clk);
        check(rdy_valid == 1'b0, "R4", "not ready before last input", rdy_valid, 0);
        do_arg(id);
        @(negedge clk);
        check(rdy_valid == 1'b1, "R4", "ready after last input", rdy_valid, 1);
        do_pop("R4", id, 16'hA0);
        @(negedge clk);
        check(rdy_valid == 1'b0, "R4", "queue empty after pop", rdy_valid, 0);
    endtask

    task automatic t_order();
        int f0, f1, f2;
        do_reset();
        do_alloc(16'h10, 1, f0);
        do_alloc(16'h11, 2, f1);
        do_alloc(16'h12, 1, f2);
        do_arg(f1); do_arg(f2); do_arg(f1); do_arg(f0);
        @(negedge clk); rdy_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rdy_fid == FID_W'(f2), "R5", "head held without ready", rdy_fid, f2);
        do_pop("R5", f2, 16'h12);
        do_pop("R5", f1, 16'h11);
        do_pop("R5", f0, 16'h10);
    endtask

    task automatic t_bad_args();
        int a, b;
        do_reset();
        do_arg(5);
        @(negedge clk);
        check(err_sticky == 1'b1, "R6", "error on unallocated frame", err_sticky, 1);
        check(rdy_valid == 1'b0, "R6", "no entry from unallocated", rdy_valid, 0);
        do_alloc(16'h30, 1, a);
        do_alloc(16'h31, 2, b);
        do_arg(a);
        do_pop("R6", a, 16'h30);
        do_arg(a);
        @(negedge clk);
        check(rdy_valid == 1'b0, "R6", "no entry from zero-count frame", rdy_valid, 0);
        do_arg(b);
        @(negedge clk);
        check(rdy_valid == 1'b0, "R6", "other count intact", rdy_valid, 0);
        do_arg(b);
        do_pop("R6", b, 16'h31);
        for (int i = 0; i < 5; i++) @(posedge clk);
        @(negedge clk);
        check(err_sticky == 1'b1, "R9", "error flag stays set", err_sticky, 1);
        do_reset();
        @(negedge clk);
        check(err_sticky == 1'b0, "R9", "error cleared by reset", err_sticky, 0);
    endtask

    task automatic t_queue_full();
        int id;
        do_reset();
        for (int i = 0; i < 9; i++) do_alloc(16'h100 + i, 1, id);
        for (int i = 0; i < QDEPTH; i++) do_arg(i);
        @(negedge clk);
        check(arg_ready == 1'b0, "R7", "arg_ready low when queue full", arg_ready, 0);
        arg_valid = 1'b1; arg_fid = 4'd8;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(arg_ready == 1'b0, "R7", "still held", arg_ready, 0);
        check(rdy_fid == 4'd0, "R7", "head unchanged while held", rdy_fid, 0);
        rdy_ready = 1'b1;
        @(posedge clk); #1 rdy_ready = 1'b0;
        @(negedge clk);
        check(arg_ready == 1'b1, "R7", "arg_ready after pop", arg_ready, 1);
        @(posedge clk); #1 arg_valid = 1'b0;
        for (int i = 1; i <= 8; i++) do_pop("R7", i, 16'h100 + i);
        @(negedge clk);
        check(err_sticky == 1'b0, "R7", "no error from held event", err_sticky, 0);
    endtask

    task automatic t_race();
        int id;
        do_reset();
        do_alloc(16'h77, 1, id);
        @(negedge clk);
        arg_valid = 1'b1; arg_fid = FID_W'(id);
        free_valid = 1'b1; free_fid = FID_W'(id);
        @(posedge clk); #1 begin arg_valid = 1'b0; free_valid = 1'b0; end
        @(negedge clk);
        check(rdy_valid == 1'b0, "R8", "no entry when release wins", rdy_valid, 0);
        check(err_sticky == 1'b0, "R8", "no error on race", err_sticky, 0);
        check(alloc_fid == FID_W'(id), "R8", "frame freed", alloc_fid, id);
    endtask

    initial begin
        t_reset_state();
        t_lowest_first();
        t_all_held();
        t_countdown();
        t_order();
        t_bad_args();
        t_queue_full();
        t_race();
        summary();
    end

    initial begin
        #(2.0 * HALF * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule